// File: doc/BRIEF.md
# SD Card Data FIFO with Level Reporting

This block is the word buffer that sits between the host's data register and the SD data-line serializer. It holds up to 16 words of 32 bits. A direction input chooses which side fills the buffer and which side drains it. In transmit direction the host writes words in and the serializer takes them out. In receive direction the serializer deposits words and the host reads them out. The oldest word is always presented on a single head-data output. Each push or pop strobe moves exactly one word.

The block keeps an occupancy count and two programmable thresholds. From these it raises a read request, when enough words are waiting for the host, and a write request, when enough space is free for the host. All three values, together with a 4-bit state code from the serializer, are packed into a debug/mode word whose field positions are fixed so that software can decode them.

An attempt to push into a full buffer, or to pop from an empty one, sets a sticky FIFO-error flag. That flag drives bit 3 of the host status word and stays set until it is cleared. A flush input, pulsed on reset initialisation or on each new command, empties the buffer in one cycle.

Top module: `sd_data_fifo`

## Requirements
- R1: Words leave the buffer in the order they entered, up to 16 words of 32 bits. The oldest stored word is shown on `head_data` in the cycle after it becomes the oldest.
- R2: With `dir_tx`=1 a `host_wr` strobe pushes `host_wdata` and a `line_pop` strobe pops. With `dir_tx`=0 a `line_push` strobe pushes `line_wdata` and a `host_rd` strobe pops. Strobes from the side that is not selected have no effect.
- R3: `fill` reports the stored word count, from 0 to 16, one cycle after each accepted strobe. An accepted push and pop in the same cycle leave it unchanged.
- R4: `dbg_view` carries the following fields, with all other bits zero:
  - bits 3:0: `line_state`
  - bits 8:4: fill
  - bits 13:9: write threshold
  - bits 18:14: read threshold
- R5: Both thresholds reset to 4. A `cfg_wr` strobe loads `cfg_wr_thr` and `cfg_rd_thr` at the next edge. A value above 16 is stored as 16.
- R6: `rd_req` is high exactly when fill is greater than or equal to the read threshold.
- R7: `wr_req` is high exactly when the free space (16 minus fill) is greater than or equal to the write threshold.
- R8: A push into a full buffer with no pop in the same cycle is dropped and sets `fifo_err`. Fill stays at 16. A push and a pop together at full are both accepted.
- R9: A pop from an empty buffer sets `fifo_err` and leaves fill unchanged. A push in the same cycle is still stored.
- R10: `fifo_err` stays set until an `err_clr` strobe. A new error in the same cycle as `err_clr` leaves the flag set.
- R11: A `flush` strobe empties the buffer at the next edge. It overrides any push or pop in that cycle, raises no error, and keeps the thresholds and the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer (reset init or new command) |
| dir_tx | input | 1 | 1: host fills, line drains; 0: line fills, host drains |
| host_wr | input | 1 | Host write strobe to the data register |
| host_wdata | input | 32 | Host write word |
| host_rd | input | 1 | Host read strobe from the data register |
| line_push | input | 1 | Serializer deposits a received word |
| line_wdata | input | 32 | Received word |
| line_pop | input | 1 | Serializer takes a word to transmit |
| head_data | output | 32 | Oldest stored word |
| line_state | input | 4 | Serializer state code for the debug view |
| cfg_wr | input | 1 | Load both thresholds |
| cfg_wr_thr | input | 5 | New write-request threshold |
| cfg_rd_thr | input | 5 | New read-request threshold |
| err_clr | input | 1 | Clear the FIFO-error flag |
| fill | output | 5 | Stored word count |
| rd_req | output | 1 | Enough words for the host to read |
| wr_req | output | 1 | Enough space for the host to write |
| fifo_err | output | 1 | Sticky overflow/underflow flag (host status bit 3) |
| dbg_view | output | 32 | Packed debug/mode word |

## Verification
The bench builds the block with its default parameters: depth 16, width 32 and 5-bit thresholds with reset value 4. At that size, completely filling and draining the buffer takes only 16 strobes, so the full and empty edges, both pointer wraps, overflow and underflow are all reached in a short run. The 5-bit threshold fields can hold 31, which lets the bench drive the clamp to 16. A threshold of 0 drives a request that stays high even with an empty buffer.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    // Field positions inside the debug/mode word; software decodes these.
    localparam int STATE_W   = 4;
    localparam int FILL_LSB  = 4;
    localparam int WTHR_LSB  = 9;
    localparam int RTHR_LSB  = 14;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } sdf_dir_e;

endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + ONE;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
        end else begin
            if (push_ok) st_d.wr_ptr = bump(st_q.wr_ptr);
            if (pop_ok)  st_d.rd_ptr = bump(st_q.rd_ptr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem_q[st_q.wr_ptr] <= wdata;
    end

    assign head = mem_q[st_q.rd_ptr];

    // R11
    flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.wr_ptr == '0) && (st_q.rd_ptr == '0));

endmodule

// File: rtl/sdf_level.sv
module sdf_level #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             err_clr,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] count,
    output logic             err
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             err;
    } lvl_t;

    lvl_t st_d, st_q;
    logic ovf, unf;

    always_comb begin
        pop_ok  = !flush && pop_req && (st_q.count != '0);
        push_ok = !flush && push_req && ((st_q.count != FULL) || pop_ok);
        ovf     = !flush && push_req && !push_ok;
        unf     = !flush && pop_req && (st_q.count == '0);

        st_d = st_q;
        if (flush) begin
            st_d.count = '0;
        end else begin
            if (push_ok) st_d.count = st_d.count + ONE;
            if (pop_ok)  st_d.count = st_d.count - ONE;
        end

        if (ovf || unf)   st_d.err = 1'b1;
        else if (err_clr) st_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign err   = st_q.err;

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && !flush && st_q.count == FULL)
        |=> (st_q.err && st_q.count == FULL));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !flush && st_q.count == '0)
        |=> (st_q.err && st_q.count == '0));

    // R3
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !flush && st_q.count != '0) |=> $stable(st_q.count));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr) |=> st_q.err);

endmodule

// File: rtl/sdf_thresh.sv
module sdf_thresh #(
    parameter int DEPTH   = 16,
    parameter int CNT_W   = $clog2(DEPTH) + 1,
    parameter int THR_W   = 5,
    parameter int THR_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [THR_W-1:0] cfg_wr_thr,
    input  logic [THR_W-1:0] cfg_rd_thr,
    input  logic [CNT_W-1:0] count,
    output logic [THR_W-1:0] wr_thr,
    output logic [THR_W-1:0] rd_thr,
    output logic             rd_req,
    output logic             wr_req
);
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam logic [THR_W-1:0] LIMIT = THR_W'(DEPTH);
    localparam logic [THR_W-1:0] INIT  = THR_W'(THR_RST);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [THR_W-1:0] wr_thr;
        logic [THR_W-1:0] rd_thr;
    } thr_t;

    thr_t st_d, st_q;
    logic [CNT_W-1:0] free_words;

    function automatic logic [THR_W-1:0] clamp(input logic [THR_W-1:0] v);
        return (v > LIMIT) ? LIMIT : v;
    endfunction

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.wr_thr = clamp(cfg_wr_thr);
            st_d.rd_thr = clamp(cfg_rd_thr);
        end
        free_words = FULL - count;
        rd_req = CMP_W'(count)      >= CMP_W'(st_q.rd_thr);
        wr_req = CMP_W'(free_words) >= CMP_W'(st_q.wr_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_thr <= INIT;
            st_q.rd_thr <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_thr = st_q.wr_thr;
    assign rd_thr = st_q.rd_thr;

    // R5
    thr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_thr <= LIMIT) && (st_q.rd_thr <= LIMIT));

    // R5
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(st_q));

endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
    import sdf_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int DEPTH   = 16,
    parameter int THR_W   = 5,
    parameter int THR_RST = 4,
    parameter int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               dir_tx,
    input  logic               host_wr,
    input  logic [WIDTH-1:0]   host_wdata,
    input  logic               host_rd,
    input  logic               line_push,
    input  logic [WIDTH-1:0]   line_wdata,
    input  logic               line_pop,
    output logic [WIDTH-1:0]   head_data,
    input  logic [STATE_W-1:0] line_state,
    input  logic               cfg_wr,
    input  logic [THR_W-1:0]   cfg_wr_thr,
    input  logic [THR_W-1:0]   cfg_rd_thr,
    input  logic               err_clr,
    output logic [CNT_W-1:0]   fill,
    output logic               rd_req,
    output logic               wr_req,
    output logic               fifo_err,
    output logic [31:0]        dbg_view
);
    sdf_dir_e         dir;
    logic             push_req, pop_req, push_ok, pop_ok;
    logic [WIDTH-1:0] wdata;
    logic [THR_W-1:0] wr_thr, rd_thr;

    always_comb begin
        dir      = sdf_dir_e'(dir_tx);
        push_req = (dir == DIR_TX) ? host_wr    : line_push;
        pop_req  = (dir == DIR_TX) ? line_pop   : host_rd;
        wdata    = (dir == DIR_TX) ? host_wdata : line_wdata;
    end

    sdf_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_req(push_req), .pop_req(pop_req), .err_clr(err_clr),
        .push_ok(push_ok), .pop_ok(pop_ok), .count(fill), .err(fifo_err)
    );

    sdf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_ok(push_ok), .pop_ok(pop_ok), .wdata(wdata), .head(head_data)
    );

    sdf_thresh #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W), .THR_RST(THR_RST)) u_thresh (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_wr_thr(cfg_wr_thr), .cfg_rd_thr(cfg_rd_thr), .count(fill),
        .wr_thr(wr_thr), .rd_thr(rd_thr), .rd_req(rd_req), .wr_req(wr_req)
    );

    always_comb begin
        dbg_view = '0;
        dbg_view[STATE_W-1:0]         = line_state;
        dbg_view[FILL_LSB +: CNT_W]   = fill;
        dbg_view[WTHR_LSB +: THR_W]   = wr_thr;
        dbg_view[RTHR_LSB +: THR_W]   = rd_thr;
    end

    // R2
    side_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && dir_tx && !host_wr && !line_pop) |=> $stable(fill));

endmodule

// File: tb/sd_data_fifo_bench.sv
module sd_data_fifo_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 0, dir_tx = 0, host_wr = 0, host_rd = 0;
    logic        line_push = 0, line_pop = 0, cfg_wr = 0, err_clr = 0;
    logic [31:0] host_wdata = '0, line_wdata = '0;
    logic [3:0]  line_state = 4'hA;
    logic [4:0]  cfg_wr_thr = '0, cfg_rd_thr = '0;
    logic [31:0] head_data, dbg_view;
    logic [4:0]  fill;
    logic        rd_req, wr_req, fifo_err;

    int n_vec = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    sd_data_fifo u_sd_data_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dir_tx(dir_tx),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .line_push(line_push), .line_wdata(line_wdata), .line_pop(line_pop),
        .head_data(head_data), .line_state(line_state),
        .cfg_wr(cfg_wr), .cfg_wr_thr(cfg_wr_thr), .cfg_rd_thr(cfg_rd_thr),
        .err_clr(err_clr), .fill(fill), .rd_req(rd_req), .wr_req(wr_req),
        .fifo_err(fifo_err), .dbg_view(dbg_view)
    );

    typedef struct packed {
        logic        dir;
        logic        hw;
        logic        hr;
        logic        lp;
        logic        lo;
        logic [31:0] dat;
        logic [4:0]  efill;
        logic        eerr;
        logic        erdq;
        logic        ewrq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,1'b0,32'hA1, 5'd1, 1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,32'hA2, 5'd2, 1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,32'hA3, 5'd3, 1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,32'hA4, 5'd4, 1'b0,1'b1,1'b1},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,32'hEE, 5'd4, 1'b0,1'b1,1'b1},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,32'hA5, 5'd4, 1'b0,1'b1,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,  5'd3, 1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,  5'd2, 1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,  5'd1, 1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,  5'd0, 1'b0,1'b0,1'b1},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,  5'd0, 1'b1,1'b0,1'b1},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,32'hB1, 5'd1, 1'b1,1'b0,1'b1},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,32'h0,  5'd0, 1'b1,1'b0,1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic hw, input logic hr,
                        input logic lp, input logic lo, input logic fl,
                        input logic ec, input logic [31:0] dat);
        dir_tx = d; host_wr = hw; host_rd = hr; line_push = lp; line_pop = lo;
        flush = fl; err_clr = ec; host_wdata = dat; line_wdata = dat;
        @(posedge clk);
        #1;
        host_wr = 0; host_rd = 0; line_push = 0; line_pop = 0;
        flush = 0; err_clr = 0; cfg_wr = 0;
    endtask

    initial begin
        #(PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // Reset state
        chk("R3", "reset fill", 32'(fill), 32'd0);
        chk("R10", "reset err", 32'(fifo_err), 32'd0);
        chk("R6", "reset rd_req", 32'(rd_req), 32'd0);
        chk("R7", "reset wr_req", 32'(wr_req), 32'd1);
        chk("R4", "reset dbg", dbg_view, 32'h0001_080A);

        // Vector walk (R2, R3, R6, R7, R9)
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].dir, VECS[i].hw, VECS[i].hr, VECS[i].lp, VECS[i].lo,
                 1'b0, 1'b0, VECS[i].dat);
            chk("R3", $sformatf("vec%0d fill", i), 32'(fill), 32'(VECS[i].efill));
            chk("R9", $sformatf("vec%0d err", i), 32'(fifo_err), 32'(VECS[i].eerr));
            chk("R6", $sformatf("vec%0d rd_req", i), 32'(rd_req), 32'(VECS[i].erdq));
            chk("R7", $sformatf("vec%0d wr_req", i), 32'(wr_req), 32'(VECS[i].ewrq));
        end

        // R10: clear, then clear colliding with a new underflow
        step(1, 0, 0, 0, 0, 0, 1, 0);
        chk("R10", "err after clear", 32'(fifo_err), 32'd0);
        step(1, 0, 0, 0, 1, 0, 1, 0);
        chk("R10", "set beats clear", 32'(fifo_err), 32'd1);
        step(1, 0, 0, 0, 0, 0, 1, 0);

        // R1/R8: fill to the brim in transmit direction
        for (int i = 0; i < 16; i++) step(1, 1, 0, 0, 0, 0, 0, 32'h100 + i);
        chk("R3", "full fill", 32'(fill), 32'd16);
        chk("R6", "full rd_req", 32'(rd_req), 32'd1);
        chk("R7", "full wr_req", 32'(wr_req), 32'd0);
        chk("R4", "full dbg fill field", 32'(dbg_view[8:4]), 32'd16);
        step(1, 1, 0, 0, 0, 0, 0, 32'hDEAD);
        chk("R8", "overflow err", 32'(fifo_err), 32'd1);
        chk("R8", "overflow fill", 32'(fill), 32'd16);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        step(1, 1, 0, 0, 1, 0, 0, 32'h200);
        chk("R8", "push+pop at full fill", 32'(fill), 32'd16);
        chk("R8", "push+pop at full err", 32'(fifo_err), 32'd0);
        for (int i = 0; i < 16; i++) begin
            chk("R1", $sformatf("drain word %0d", i), head_data,
                (i < 15) ? 32'h101 + i : 32'h200);
            step(1, 0, 0, 0, 1, 0, 0, 0);
        end
        chk("R1", "drained fill", 32'(fill), 32'd0);
        chk("R1", "drained err", 32'(fifo_err), 32'd0);

        // R9: underflow with a push in the same cycle
        step(1, 1, 0, 0, 1, 0, 0, 32'h77);
        chk("R9", "pop-empty err", 32'(fifo_err), 32'd1);
        chk("R9", "pop-empty push kept", 32'(fill), 32'd1);
        chk("R9", "pop-empty head", head_data, 32'h77);

        // R11: flush
        step(1, 1, 0, 0, 0, 0, 0, 32'h78);
        step(1, 1, 0, 0, 0, 0, 0, 32'h79);
        step(1, 0, 0, 0, 0, 1, 0, 0);
        chk("R11", "flush fill", 32'(fill), 32'd0);
        chk("R11", "flush keeps err", 32'(fifo_err), 32'd1);
        step(1, 1, 0, 0, 0, 1, 1, 32'h80);
        chk("R11", "flush beats push", 32'(fill), 32'd0);
        step(1, 1, 0, 0, 0, 0, 0, 32'h55);
        chk("R11", "after flush head", head_data, 32'h55);
        chk("R11", "after flush fill", 32'(fill), 32'd1);

        // R5: threshold load with clamp
        cfg_wr = 1; cfg_wr_thr = 5'd31; cfg_rd_thr = 5'd2;
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R5", "wr thr clamped", 32'(dbg_view[13:9]), 32'd16);
        chk("R5", "rd thr loaded", 32'(dbg_view[18:14]), 32'd2);
        chk("R6", "fill1 thr2 rd_req", 32'(rd_req), 32'd0);
        step(1, 1, 0, 0, 0, 0, 0, 32'h56);
        chk("R6", "fill2 thr2 rd_req", 32'(rd_req), 32'd1);
        chk("R7", "free14 thr16 wr_req", 32'(wr_req), 32'd0);
        step(1, 0, 0, 0, 0, 1, 0, 0);
        chk("R7", "free16 thr16 wr_req", 32'(wr_req), 32'd1);
        cfg_wr = 1; cfg_wr_thr = 5'd4; cfg_rd_thr = 5'd0;
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk("R6", "thr0 rd_req at empty", 32'(rd_req), 32'd1);
        chk("R4", "dbg after reload", dbg_view, 32'h0000_080A);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule